// File: doc/BRIEF.md
# Out-of-Order Memory Read Tracker

This block sits on the host side of a memory channel shared with a module whose read latency varies. Each accepted read request is sent straight on as a read command. The command carries a small tag, and that tag is the index of a free slot in an outstanding-read table. The module keeps the reads in its own buffer and raises a ready strobe whenever any one of them has its data in hand. The tracker answers every strobe with a one-cycle send command. A fixed number of cycles after that send, it captures the response lines: data, returned tag, write-credit count, check bits and poison flag.

The returned tag is looked up in the outstanding table. A tag that is outstanding retires its slot and goes to the requester as a completion, so completions arrive in whatever order the module chooses. A tag that is not outstanding raises a one-cycle error and is discarded. The credit count in every captured response is passed on, whether or not the tag matched. The check bits are forwarded without correction.

Top module: `ooo_read_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `cmd_rd_valid`, `cmd_send`, `cpl_valid`, `id_err` and `credit_valid` are 0.
- R2: `cmd_rd_valid` is high in the same cycle as `req_valid && req_ready`. In that cycle `cmd_rd_addr` equals `req_addr`, and `cmd_rd_id` is the lowest-numbered tag (0 to 15) that is not outstanding.
- R3: Up to 16 reads can be outstanding at once. While all 16 tags are outstanding, `req_ready` is 0 and no read command is issued.
- R4: A tag retires at the clock edge that captures its matching response. It can be handed out again from the next cycle onward.
- R5: For each cycle in which `mod_rdy` is high, `cmd_send` is high for exactly one cycle, on the next cycle. Strobes in consecutive cycles give sends in consecutive cycles.
- R6: The response inputs are sampled in the cycle exactly SEND_DLY cycles (4 by default) after a cycle with `cmd_send` high, and in no other cycle.
- R7: A sampled response whose tag is outstanding gives `cpl_valid` high in the next cycle. In that cycle `cpl_id`, `cpl_data` and `cpl_ecc` equal the sampled tag, data and check bits, whatever the issue order was.
- R8: `cpl_err` equals the sampled poison flag when `cpl_valid` is high, and is 0 when `cpl_valid` is low.
- R9: A sampled response whose tag is not outstanding gives `id_err` high for one cycle in the next cycle. `cpl_valid` stays 0 and the outstanding set does not change.
- R10: Every sampled response gives `credit_valid` high in the next cycle, with `wr_credit` equal to the sampled credit count. This holds for unmatched tags as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Read request address |
| req_ready | output | 1 | A free tag exists; request accepted when both valid and ready |
| cmd_rd_valid | output | 1 | Read command to the module this cycle |
| cmd_rd_id | output | ID_W | Tag attached to the read command |
| cmd_rd_addr | output | ADDR_W | Address of the read command |
| mod_rdy | input | 1 | Module strobe: some buffered read has data ready |
| cmd_send | output | 1 | Send command asking the module to return one ready read |
| rsp_id | input | ID_W | Returned tag, valid in the sample cycle |
| rsp_data | input | DATA_W | Returned data |
| rsp_credit | input | CRED_W | Write-credit count from the response metadata |
| rsp_ecc | input | ECC_W | Channel check bits from the response metadata |
| rsp_poison | input | 1 | Poison flag from the response metadata |
| cpl_valid | output | 1 | Completion to the requester |
| cpl_id | output | ID_W | Tag of the completion |
| cpl_data | output | DATA_W | Completion data |
| cpl_ecc | output | ECC_W | Completion check bits, uncorrected |
| cpl_err | output | 1 | Completion carries poisoned data |
| id_err | output | 1 | Pulse: response with a tag that is not outstanding was dropped |
| credit_valid | output | 1 | Pulse: `wr_credit` holds a fresh credit count |
| wr_credit | output | CRED_W | Write credits returned by the module |

## Verification
Three timings are checked. The read command and its tag are combinational, so they are checked 1 ns after the inputs change, within the cycle of the request. A send is due one cycle after its strobe. A completion, error or credit is due SEND_DLY+2 cycles after the strobe: one cycle to the send, SEND_DLY cycles to the sample, and one more to the registered output. The bench's module model drives the response only in its sample cycle and zeros at all other times, so sampling in the wrong cycle shows up as a data mismatch. Every registered output is compared against the reference model at each falling edge, half a cycle after the edge that updates it.

// File: rtl/ooo_read_tracker.sv
module ooo_read_tracker #(
  parameter int ID_W     = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int CRED_W   = 4,
  parameter int ECC_W    = 8,
  parameter int SEND_DLY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              cmd_rd_valid,
  output logic [ID_W-1:0]   cmd_rd_id,
  output logic [ADDR_W-1:0] cmd_rd_addr,
  input  logic              mod_rdy,
  output logic              cmd_send,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [CRED_W-1:0] rsp_credit,
  input  logic [ECC_W-1:0]  rsp_ecc,
  input  logic              rsp_poison,
  output logic              cpl_valid,
  output logic [ID_W-1:0]   cpl_id,
  output logic [DATA_W-1:0] cpl_data,
  output logic [ECC_W-1:0]  cpl_ecc,
  output logic              cpl_err,
  output logic              id_err,
  output logic              credit_valid,
  output logic [CRED_W-1:0] wr_credit
);
  localparam int NUM_IDS = 1 << ID_W;

  logic [NUM_IDS-1:0]  busy;
  logic [ID_W-1:0]     free_id;
  logic [SEND_DLY-1:0] send_pipe;
  logic                sample, hit;
  logic [NUM_IDS-1:0]  set_mask, clr_mask;

  always_comb begin
    free_id = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--)
      if (!busy[i]) free_id = ID_W'(i);
  end

  assign req_ready    = ~&busy;
  assign cmd_rd_valid = req_valid & req_ready;
  assign cmd_rd_id    = free_id;
  assign cmd_rd_addr  = req_addr;

  assign sample   = send_pipe[SEND_DLY-1];
  assign hit      = sample & busy[rsp_id];
  assign set_mask = cmd_rd_valid ? (NUM_IDS'(1) << free_id) : '0;
  assign clr_mask = hit ? (NUM_IDS'(1) << rsp_id) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= '0;
      send_pipe    <= '0;
      cmd_send     <= 1'b0;
      cpl_valid    <= 1'b0;
      cpl_id       <= '0;
      cpl_data     <= '0;
      cpl_ecc      <= '0;
      cpl_err      <= 1'b0;
      id_err       <= 1'b0;
      credit_valid <= 1'b0;
      wr_credit    <= '0;
    end else begin
      busy         <= (busy & ~clr_mask) | set_mask;
      cmd_send     <= mod_rdy;
      send_pipe    <= (send_pipe << 1) | SEND_DLY'(cmd_send);
      cpl_valid    <= hit;
      cpl_err      <= hit & rsp_poison;
      id_err       <= sample & ~hit;
      credit_valid <= sample;
      if (sample) begin
        cpl_id    <= rsp_id;
        cpl_data  <= rsp_data;
        cpl_ecc   <= rsp_ecc;
        wr_credit <= rsp_credit;
      end
    end
  end
endmodule

// File: rtl/ooo_read_tracker_chk.sv
module ooo_read_tracker_chk #(
  parameter int ID_W     = 4,
  parameter int SEND_DLY = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            cmd_rd_valid,
  input logic [ID_W-1:0] cmd_rd_id,
  input logic            mod_rdy,
  input logic            cmd_send,
  input logic            cpl_valid,
  input logic [ID_W-1:0] cpl_id,
  input logic            cpl_err,
  input logic            id_err,
  input logic            credit_valid
);
  localparam int NUM_IDS = 1 << ID_W;

  logic [NUM_IDS-1:0] chk_busy;
  logic [SEND_DLY:0]  chk_pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_busy <= '0;
      chk_pipe <= '0;
    end else begin
      chk_pipe <= (chk_pipe << 1) | (SEND_DLY+1)'(cmd_send);
      chk_busy <= (chk_busy & ~(cpl_valid ? (NUM_IDS'(1) << cpl_id) : '0))
                | (cmd_rd_valid ? (NUM_IDS'(1) << cmd_rd_id) : '0);
    end
  end

  AST_SEND_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n) mod_rdy |=> cmd_send); // R5
  AST_NO_SPURIOUS_SEND: assert property (@(posedge clk) disable iff (!rst_n) !mod_rdy |=> !cmd_send); // R5
  AST_SAMPLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n) credit_valid == chk_pipe[SEND_DLY]); // R6
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n) !req_ready |-> &chk_busy); // R3
  AST_FRESH_ID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd_valid |-> (!chk_busy[cmd_rd_id] || (cpl_valid && cpl_id == cmd_rd_id))); // R2
  AST_CPL_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) cpl_valid |-> chk_busy[cpl_id]); // R7
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) id_err |-> (!cpl_valid && credit_valid)); // R9
  AST_POISON_QUAL: assert property (@(posedge clk) disable iff (!rst_n) cpl_err |-> cpl_valid); // R8
endmodule

bind ooo_read_tracker ooo_read_tracker_chk #(.ID_W(ID_W), .SEND_DLY(SEND_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_rd_valid(cmd_rd_valid),
  .cmd_rd_id(cmd_rd_id), .mod_rdy(mod_rdy), .cmd_send(cmd_send), .cpl_valid(cpl_valid),
  .cpl_id(cpl_id), .cpl_err(cpl_err), .id_err(id_err), .credit_valid(credit_valid)
);

// File: tb/ooo_read_tracker_test.sv
module ooo_read_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, cmd_rd_valid, mod_rdy, cmd_send;
  logic [31:0] req_addr, cmd_rd_addr;
  logic [3:0]  cmd_rd_id, rsp_id, cpl_id, rsp_credit, wr_credit;
  logic [63:0] rsp_data, cpl_data;
  logic [7:0]  rsp_ecc, cpl_ecc;
  logic        rsp_poison, cpl_valid, cpl_err, id_err, credit_valid;

  always #4 clk = ~clk;

  ooo_read_tracker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .cmd_rd_valid(cmd_rd_valid), .cmd_rd_id(cmd_rd_id), .cmd_rd_addr(cmd_rd_addr),
    .mod_rdy(mod_rdy), .cmd_send(cmd_send), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .rsp_credit(rsp_credit), .rsp_ecc(rsp_ecc), .rsp_poison(rsp_poison),
    .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_data(cpl_data), .cpl_ecc(cpl_ecc),
    .cpl_err(cpl_err), .id_err(id_err), .credit_valid(credit_valid), .wr_credit(wr_credit)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  bit mbusy[16];
  logic [31:0] maddr[16];
  bit due_v[64], due_p[64];
  logic [3:0] due_id[64], due_c[64];
  bit e_send, e_cpl, e_err, e_cred, e_poison;
  logic [3:0] e_id, e_credit;
  logic [63:0] e_data;
  logic [7:0] e_ecc;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", r, cyc, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < 16; i++) if (!mbusy[i]) return i;
    return -1;
  endfunction

  task automatic step(bit rv, logic [31:0] a, bit rdy, int sid, bit poi, logic [3:0] cr);
    int s, lf;
    bit hit;
    s = cyc % 64;
    req_valid = rv; req_addr = a; mod_rdy = rdy;
    if (due_v[s]) begin
      rsp_id = due_id[s]; rsp_poison = due_p[s]; rsp_credit = due_c[s];
      rsp_ecc = {4'hE, due_id[s]};
      rsp_data = {28'hDA7A000, due_id[s], maddr[due_id[s]]};
    end else begin
      rsp_id = '0; rsp_poison = 0; rsp_credit = '0; rsp_ecc = '0; rsp_data = '0;
    end
    #1;
    lf = lowest_free();
    chk("R3 req_ready", req_ready, lf >= 0);
    chk("R2 cmd_rd_valid", cmd_rd_valid, rv && lf >= 0);
    if (rv && lf >= 0) begin
      chk("R2 cmd_rd_id", cmd_rd_id, lf);
      chk("R2 cmd_rd_addr", cmd_rd_addr, a);
    end
    @(posedge clk);
    e_send = rdy;
    e_cred = due_v[s];
    e_cpl = 0; e_err = 0;
    if (due_v[s]) begin
      hit = mbusy[due_id[s]];
      e_cpl = hit; e_err = !hit;
      e_id = due_id[s]; e_credit = due_c[s]; e_poison = due_p[s];
      e_data = rsp_data; e_ecc = rsp_ecc;
      if (hit) mbusy[due_id[s]] = 0;
    end
    if (rv && lf >= 0) begin mbusy[lf] = 1; maddr[lf] = a; end
    due_v[s] = 0;
    if (rdy) begin
      due_v[(cyc + 5) % 64] = 1; due_id[(cyc + 5) % 64] = 4'(sid);
      due_p[(cyc + 5) % 64] = poi; due_c[(cyc + 5) % 64] = cr;
    end
    cyc++;
    @(negedge clk);
    chk("R5 cmd_send", cmd_send, e_send);
    chk("R10 credit_valid", credit_valid, e_cred);
    chk("R7 cpl_valid", cpl_valid, e_cpl);
    chk("R9 id_err", id_err, e_err);
    chk("R8 cpl_err", cpl_err, e_cpl && e_poison);
    if (e_cred) chk("R10 wr_credit", wr_credit, e_credit);
    if (e_cpl) begin
      chk("R7 cpl_id", cpl_id, e_id);
      chk("R6 cpl_data", cpl_data, e_data);
      chk("R7 cpl_ecc", cpl_ecc, e_ecc);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, '0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; mod_rdy = 0;
    rsp_id = '0; rsp_data = '0; rsp_credit = '0; rsp_ecc = '0; rsp_poison = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 cmd_rd_valid", cmd_rd_valid, 0);
    chk("R1 cmd_send", cmd_send, 0);
    chk("R1 cpl_valid", cpl_valid, 0);
    chk("R1 id_err", id_err, 0);
    chk("R1 credit_valid", credit_valid, 0);
    rst_n = 1;
    // R2 issue, R5/R7 out-of-order returns, R8 poison
    step(1, 32'h1000, 0, 0, 0, 0);
    step(1, 32'h1040, 0, 0, 0, 0);
    step(1, 32'h1080, 0, 0, 0, 0);
    step(0, '0, 1, 2, 0, 4'd3);
    idle(2);
    step(0, '0, 1, 0, 0, 4'd1);
    step(0, '0, 1, 1, 1, 4'd2);
    idle(8);
    // R3 fill all tags, then stall
    for (int i = 0; i < 17; i++) step(1, 32'h2000 + 32'(i) * 64, 0, 0, 0, 0);
    // R4 retire tag 9 while requesting; it is reissued
    step(1, 32'h3000, 1, 9, 0, 4'd5);
    for (int i = 0; i < 8; i++) step(1, 32'h3100 + 32'(i), 0, 0, 0, 0);
    // R9 unknown tag: retire 3, then return 3 again
    step(0, '0, 1, 3, 0, 4'd7);
    idle(7);
    step(0, '0, 1, 3, 1, 4'd6);
    idle(7);
    step(1, 32'h4000, 0, 0, 0, 0);
    // R5 back-to-back strobes, scrambled order
    for (int i = 0; i < 16; i++) step(0, '0, 1, (i * 5) % 16, i[0], 4'(i));
    idle(10);
    step(1, 32'h5000, 0, 0, 0, 0);
    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule